// File: doc/BRIEF.md
# Automatic Two-Stage SCLK Divider

This block turns a pair of rates, the frequency of its own clock (`req_fin`) and the serial clock frequency wanted (`req_fspi`), into the settings of a two-stage divider. It then runs that divider to produce a serial clock. The first stage divides by `pre+1` and the second by `2^post`, where both settings are 4-bit values. The serial clock rate that results is therefore `fin/(pre+1)/2^post`.

Settings are chosen by a short sequencer. It first finds the smallest power-of-two shift that brings the requested rate up to the input rate, using the positions of the leading one bits. It then allows the first stage to take up to a factor of sixteen and obtains the first-stage setting by a ceiling division. The sequencer reports the rate actually achieved, and it raises an error when no legal setting exists.

The divider switches to new settings only at the end of a full serial clock period, so the output clock never carries a runt pulse. Along with the clock it produces a sample strobe on each rising edge and a shift strobe on each falling edge.

Top module: `sclk_div_auto`

## Requirements
- R1: `req_ready` is high whenever the sequencer is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high, and `req_ready` then stays low until the result is reported.
- R2: A request with `req_fspi` equal to zero, or with `req_fspi` greater than `req_fin`, is rejected with `res_err` high.
- R3: The shift `post` is chosen in four steps. It starts as the bit length of `fin` minus the bit length of `fspi`. It is raised by one if `fin > (fspi << post)`. Four is then subtracted. A negative result is held at zero.
- R4: If the `post` found this way exceeds 15, the request fails with `res_err` high. In that case the divider settings in force and the reported values are left unchanged.
- R5: `pre = ceil(fin / (fspi << post)) - 1`. The reported rate is `res_rate = (fin / (pre+1)) >> post`, and it never exceeds the requested rate.
- R6: `res_word` carries `pre` in bits 15:12 and `post` in bits 11:8. Bits 7:0 are zero.
- R7: `res_done` is a single-cycle pulse. In that cycle `res_err`, `res_pre`, `res_post`, `res_word` and `res_rate` are valid. After a failed request, the four value outputs keep the values of the last successful request.
- R8: One serial clock period lasts `(pre+1)*2^post` clock cycles. `sclk` is high for the first `floor(period/2)` cycles of the period and low for the rest. `sample_stb` pulses in the cycle where `sclk` rises, and `shift_stb` pulses in the cycle where `sclk` falls.
- R9: After reset the divider runs with `pre=1` and `post=0`, which gives a period of 2 cycles. Settings from a successful request take effect only at the end of a whole period of the settings already in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its frequency is the `fin` of a request |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_fin | input | 32 | Input clock rate |
| req_fspi | input | 32 | Requested serial clock rate |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| res_done | output | 1 | One-cycle result pulse |
| res_err | output | 1 | Request could not be met |
| res_pre | output | 4 | First-stage setting |
| res_post | output | 4 | Second-stage shift |
| res_word | output | 16 | Packed settings word |
| res_rate | output | 32 | Achieved serial clock rate |
| sclk | output | 1 | Serial clock |
| sample_stb | output | 1 | Pulse at each sclk rise |
| shift_stb | output | 1 | Pulse at each sclk fall |

## Verification
A wrong intermediate shift or quotient inside the sequencer shows up in the same `res_done` cycle as a wrong `res_pre`, `res_post` or `res_rate`. A wrong active setting in the clock generator shows up within one serial clock period as a wrong spacing between `sample_stb` pulses, or as a wrong count of `sclk` high cycles. A failed request that wrongly disturbs the settings shows up in the values held on the result outputs and in the next measured period. The scoreboard holds predicted results that are worked out from the formulas in the requirements, and the checks then time the clock against those predictions.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  typedef enum logic [2:0] {
    C_IDLE,
    C_EST,
    C_ADJ,
    C_CLAMP,
    C_DIV1,
    C_DIV2,
    C_DONE
  } calc_state_t;
endpackage

// File: rtl/sclk_div_divider.sv
// Restoring divider, one quotient bit per cycle.
module sclk_div_divider #(
  parameter int W  = 32,
  parameter int DW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  dividend,
  input  logic [DW-1:0] divisor,
  output logic          done,
  output logic [W-1:0]  quo,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [DW-1:0] dsr_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [DW-1:0] r_sh;
  logic          fits;

  assign r_sh = {rem[DW-2:0], quo[W-1]};
  assign fits = (r_sh >= dsr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
      quo    <= '0;
      rem    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dsr_q  <= divisor;
        quo    <= dividend;
        rem    <= '0;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem   <= fits ? (r_sh - dsr_q) : r_sh;
        quo   <= {quo[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sclk_div_calc.sv
// Setting selection sequencer.
module sclk_div_calc
  import sclk_div_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = 4,
  parameter int DW = W + (1 << SW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [W-1:0]  req_fin,
  input  logic [W-1:0]  req_fspi,
  output logic          req_ready,
  output logic          div_start,
  output logic [W-1:0]  div_dividend,
  output logic [DW-1:0] div_divisor,
  input  logic          div_done,
  input  logic [W-1:0]  div_quo,
  input  logic [DW-1:0] div_rem,
  output logic          res_done,
  output logic          res_err,
  output logic [SW-1:0] res_pre,
  output logic [SW-1:0] res_post,
  output logic [W-1:0]  res_rate,
  output logic          set_valid
);
  localparam int PW      = $clog2(W) + 1;
  localparam int MAXPOST = (1 << SW) - 1;
  localparam int TW      = 2 * W;

  function automatic logic [PW-1:0] bitlen(input logic [W-1:0] x);
    logic [PW-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++)
      if (x[i]) r = PW'(i + 1);
    return r;
  endfunction

  calc_state_t   st_q;
  logic [W-1:0]  fin_q, fspi_q;
  logic [PW-1:0] post_q;
  logic [SW-1:0] pre_q;
  logic          err_q;
  logic [W-1:0]  rate_q;
  logic [PW-1:0] post_cl;
  logic [W:0]    ceil_q;

  assign req_ready    = (st_q == C_IDLE);
  assign div_dividend = fin_q;
  assign div_divisor  = (st_q == C_DIV1) ? (DW'(fspi_q) << post_q)
                                         : DW'({1'b0, pre_q} + 1'b1);
  assign post_cl      = (post_q < PW'(4)) ? '0 : post_q - PW'(4);
  assign ceil_q       = {1'b0, div_quo} + ((div_rem != '0) ? 1'b1 : 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= C_IDLE;
      fin_q     <= '0;
      fspi_q    <= '0;
      post_q    <= '0;
      pre_q     <= '0;
      err_q     <= 1'b0;
      rate_q    <= '0;
      div_start <= 1'b0;
      res_done  <= 1'b0;
      res_err   <= 1'b0;
      res_pre   <= SW'(1);
      res_post  <= '0;
      res_rate  <= '0;
      set_valid <= 1'b0;
    end else begin
      div_start <= 1'b0;
      res_done  <= 1'b0;
      set_valid <= 1'b0;
      case (st_q)
        C_IDLE: if (req_valid) begin
          fin_q  <= req_fin;
          fspi_q <= req_fspi;
          err_q  <= 1'b0;
          st_q   <= C_EST;
        end
        C_EST: begin
          if (fspi_q == '0 || fspi_q > fin_q) begin
            err_q <= 1'b1;
            st_q  <= C_DONE;
          end else begin
            post_q <= bitlen(fin_q) - bitlen(fspi_q);
            st_q   <= C_ADJ;
          end
        end
        C_ADJ: begin
          if (TW'(fin_q) > (TW'(fspi_q) << post_q)) post_q <= post_q + 1'b1;
          st_q <= C_CLAMP;
        end
        C_CLAMP: begin
          if (post_cl > PW'(MAXPOST)) begin
            err_q <= 1'b1;
            st_q  <= C_DONE;
          end else begin
            post_q    <= post_cl;
            div_start <= 1'b1;
            st_q      <= C_DIV1;
          end
        end
        C_DIV1: if (div_done) begin
          pre_q     <= SW'(ceil_q - 1'b1);
          div_start <= 1'b1;
          st_q      <= C_DIV2;
        end
        C_DIV2: if (div_done) begin
          rate_q <= div_quo >> post_q;
          st_q   <= C_DONE;
        end
        C_DONE: begin
          res_done <= 1'b1;
          res_err  <= err_q;
          if (!err_q) begin
            res_pre   <= pre_q;
            res_post  <= SW'(post_q);
            res_rate  <= rate_q;
            set_valid <= 1'b1;
          end
          st_q <= C_IDLE;
        end
        default: st_q <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sclk_div_gen.sv
// Two-counter serial clock generator with boundary-only updates.
module sclk_div_gen #(
  parameter int SW       = 4,
  parameter int RST_PRE  = 1,
  parameter int RST_POST = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_valid,
  input  logic [SW-1:0] set_pre,
  input  logic [SW-1:0] set_post,
  output logic          sclk,
  output logic          sample_stb,
  output logic          shift_stb
);
  localparam int PCW = (1 << SW) - 1;

  logic [SW-1:0]  act_pre, act_post, pend_pre, pend_post;
  logic           pend_q;
  logic [SW-1:0]  pre_cnt;
  logic [PCW-1:0] post_cnt;
  logic [PCW:0]   span;
  logic [PCW-1:0] post_lim, half_post;
  logic [SW-1:0]  half_pre;
  logic           wrap_pre, period_end, hi, at_half, at_zero;

  assign span       = (PCW + 1)'(1) << act_post;
  assign post_lim   = PCW'(span - 1'b1);
  assign half_post  = PCW'(span >> 1);
  assign half_pre   = SW'(({1'b0, act_pre} + 1'b1) >> 1);
  assign wrap_pre   = (pre_cnt == act_pre);
  assign period_end = wrap_pre && (post_cnt == post_lim);
  assign at_zero    = (pre_cnt == '0) && (post_cnt == '0);
  assign hi         = (act_post == '0) ? (pre_cnt < half_pre) : (post_cnt < half_post);
  assign at_half    = (act_post == '0) ? ((post_cnt == '0) && (pre_cnt == half_pre))
                                       : ((pre_cnt == '0) && (post_cnt == half_post));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_pre    <= SW'(RST_PRE);
      act_post   <= SW'(RST_POST);
      pend_pre   <= '0;
      pend_post  <= '0;
      pend_q     <= 1'b0;
      pre_cnt    <= '0;
      post_cnt   <= '0;
      sclk       <= 1'b0;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else begin
      sclk       <= hi;
      sample_stb <= at_zero;
      shift_stb  <= at_half;
      if (period_end) begin
        pre_cnt  <= '0;
        post_cnt <= '0;
        if (pend_q) begin
          act_pre  <= pend_pre;
          act_post <= pend_post;
          pend_q   <= 1'b0;
        end
      end else if (wrap_pre) begin
        pre_cnt  <= '0;
        post_cnt <= post_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
      if (set_valid) begin
        pend_q    <= 1'b1;
        pend_pre  <= set_pre;
        pend_post <= set_post;
      end
    end
  end
endmodule

// File: rtl/sclk_div_auto.sv
module sclk_div_auto #(
  parameter int W        = 32,
  parameter int SW       = 4,
  parameter int RST_PRE  = 1,
  parameter int RST_POST = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [W-1:0]    req_fin,
  input  logic [W-1:0]    req_fspi,
  output logic            req_ready,
  output logic            res_done,
  output logic            res_err,
  output logic [SW-1:0]   res_pre,
  output logic [SW-1:0]   res_post,
  output logic [4*SW-1:0] res_word,
  output logic [W-1:0]    res_rate,
  output logic            sclk,
  output logic            sample_stb,
  output logic            shift_stb
);
  localparam int DW = W + (1 << SW);

  logic          div_start, div_done, set_valid;
  logic [W-1:0]  div_dividend, div_quo;
  logic [DW-1:0] div_divisor, div_rem;

  sclk_div_calc #(.W(W), .SW(SW), .DW(DW)) u_calc (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_fin(req_fin), .req_fspi(req_fspi),
    .req_ready(req_ready),
    .div_start(div_start), .div_dividend(div_dividend), .div_divisor(div_divisor),
    .div_done(div_done), .div_quo(div_quo), .div_rem(div_rem),
    .res_done(res_done), .res_err(res_err), .res_pre(res_pre),
    .res_post(res_post), .res_rate(res_rate), .set_valid(set_valid)
  );

  sclk_div_divider #(.W(W), .DW(DW)) u_div (
    .clk(clk), .rst(rst), .start(div_start),
    .dividend(div_dividend), .divisor(div_divisor),
    .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  sclk_div_gen #(.SW(SW), .RST_PRE(RST_PRE), .RST_POST(RST_POST)) u_gen (
    .clk(clk), .rst(rst), .set_valid(set_valid),
    .set_pre(res_pre), .set_post(res_post),
    .sclk(sclk), .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  assign res_word = {res_pre, res_post, (2*SW)'(0)};
endmodule

// File: rtl/sclk_div_auto_chk.sv
module sclk_div_auto_chk #(
  parameter int W  = 32,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [W-1:0]  req_fspi,
  input logic          res_done,
  input logic          res_err,
  input logic [SW-1:0] res_pre,
  input logic [SW-1:0] res_post,
  input logic [W-1:0]  res_rate,
  input logic          sclk,
  input logic          sample_stb,
  input logic          shift_stb
);
  logic [W-1:0] fspi_seen;

  always_ff @(posedge clk) begin
    if (rst) fspi_seen <= '0;
    else if (req_valid && req_ready) fspi_seen <= req_fspi;
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    res_done |=> !res_done);

  a_r4_err_holds: assert property (@(posedge clk) disable iff (rst)
    (res_done && res_err) |-> ($stable(res_pre) && $stable(res_post) && $stable(res_rate)));

  a_r5_rate_bound: assert property (@(posedge clk) disable iff (rst)
    (res_done && !res_err) |-> (res_rate <= fspi_seen));

  a_r8_rise_sample: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> sample_stb);

  a_r8_fall_shift: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> shift_stb);
endmodule

bind sclk_div_auto sclk_div_auto_chk #(.W(W), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_fspi(req_fspi), .res_done(res_done), .res_err(res_err),
  .res_pre(res_pre), .res_post(res_post), .res_rate(res_rate),
  .sclk(sclk), .sample_stb(sample_stb), .shift_stb(shift_stb)
);

// File: tb/sclk_div_auto_tb.sv
module sclk_div_auto_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_fin = '0, req_fspi = '0;
  logic        req_ready, res_done, res_err, sclk, sample_stb, shift_stb;
  logic [3:0]  res_pre, res_post;
  logic [15:0] res_word;
  logic [31:0] res_rate;

  int errors = 0;
  int checks = 0;
  int cur_pre = 1, cur_post = 0;
  longint cur_rate = 0;

  typedef struct { bit err; int pre; int post; longint rate; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  sclk_div_auto u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_fin(req_fin),
    .req_fspi(req_fspi), .req_ready(req_ready), .res_done(res_done),
    .res_err(res_err), .res_pre(res_pre), .res_post(res_post),
    .res_word(res_word), .res_rate(res_rate), .sclk(sclk),
    .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bitlen(input longint x);
    int r = 0;
    for (int i = 0; i < 40; i++) if (x[i]) r = i + 1;
    return r;
  endfunction

  // Prediction from the formulas in R2..R5.
  function automatic exp_t predict(input longint fin, input longint fspi);
    exp_t e;
    int p;
    longint d, c;
    e.err = 1'b0;
    if (fspi == 0 || fspi > fin) e.err = 1'b1;
    else begin
      p = bitlen(fin) - bitlen(fspi);
      if (fin > (fspi << p)) p++;
      p = (p < 4) ? 0 : p - 4;
      if (p > 15) e.err = 1'b1;
      else begin
        d = fspi << p;
        c = (fin + d - 1) / d;
        e.pre = int'(c - 1);
        e.post = p;
        e.rate = (fin / (c)) >> p;
      end
    end
    if (e.err) begin
      e.pre = cur_pre; e.post = cur_post; e.rate = cur_rate;
    end else begin
      cur_pre = e.pre; cur_post = e.post; cur_rate = e.rate;
    end
    return e;
  endfunction

  // Driver: push prediction, present request for one accepted cycle.
  task automatic send(input longint fin, input longint fspi);
    sb_q.push_back(predict(fin, fspi));
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_fin = 32'(fin);
    req_fspi = 32'(fspi);
    @(negedge clk);
    check("R1 ready low after accept", req_ready, 0);
    req_valid = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // Monitor: compare each result pulse with the head of the scoreboard.
  always @(negedge clk) begin
    if (!rst && res_done) begin
      exp_t e;
      if (sb_q.size() == 0) begin
        check("R7 unexpected result", 1, 0);
      end else begin
        e = sb_q.pop_front();
        check("R2/R4 error flag", res_err, e.err);
        check("R3/R4 post", res_post, e.post);
        check("R5/R7 pre", res_pre, e.pre);
        check("R5 rate", res_rate, e.rate);
        check("R6 word", res_word, {4'(e.pre), 4'(e.post), 8'h00});
      end
    end
  end

  // Period between sample pulses and sclk high time within it (R8, R9).
  task automatic measure(input int pre, input int post);
    int c, h, p;
    p = (pre + 1) << post;
    repeat (3) begin
      @(negedge clk);
      while (!sample_stb) @(negedge clk);
    end
    h = sclk ? 1 : 0;
    c = 1;
    forever begin
      @(negedge clk);
      if (sample_stb) break;
      c++;
      if (sclk) h++;
    end
    check("R8 period", c, p);
    check("R8 high time", h, p / 2);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 ready after reset", req_ready, 1);
    check("R7 no done after reset", res_done, 0);
    measure(1, 0);                          // R9 reset settings
    send(100_000_000, 10_000_000); measure(cur_pre, cur_post);
    send(1000, 7);                 measure(cur_pre, cur_post);
    send(66_000_000, 1_000_000);   measure(cur_pre, cur_post);
    send(10, 11);                  measure(cur_pre, cur_post);  // R2, R4 hold
    send(50, 0);                   measure(cur_pre, cur_post);  // R2 zero rate
    send(1 << 20, 1);              measure(cur_pre, cur_post);  // R4 post 16
    send(100, 100);                measure(cur_pre, cur_post);  // R8 period 1
    send(64'd2147483648, 1);                                    // R4 post 27
    send(50000, 3);                measure(cur_pre, cur_post);  // R3 post 11
    send(1 << 19, 1);                                           // R3 post 15 limit
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule